// File: doc/BRIEF.md
# Configurable-Frame UART Transmitter

This block turns queued characters into asynchronous serial frames on a single line. Characters enter a 16-entry queue through a valid/ready push port. A serializer takes them one at a time and sends each frame as follows: a low start bit, then 1 to 8 data bits with the least significant bit first, then an optional parity bit, then one or two high stop bits. Each bit lasts 16 pulses of an external oversample tick, so the tick rate sets the baud rate and the system clock does not.

The frame shape comes from plain configuration pins: word length, parity enable, parity sense and stop count. The serializer captures them when a frame begins. An optional handshake holds off new frames while the clear-to-send input is low. A break override forces the line low. The block also reports how many characters are queued, and it keeps a transmitter-ready flag. The flag is raised whenever the queue fill is at or below a programmable threshold, and software commands can clear it or set it.

Back-pressure rules on the push port work like this. A character is accepted on a clock edge where `push_valid` and `push_ready` are both high and no queue clear is requested. `push_ready` is low exactly when 16 characters are queued. A `push_valid` pulse while `push_ready` is low is dropped and changes nothing. The character being serialized no longer counts as queued.

Top module: `cfg_uart_tx`

## Requirements
- R1: Reset state: after reset, `txd` is 1, `fifo_count` is 0, `push_ready` is 1 and `tx_ready` is 1.
- R2: A frame starts with one 0 bit, followed by `cfg_wlen`+1 data bits sent LSB first (`cfg_wlen` = 7 gives 8 bits). Each bit lasts 16 pulses of `tick16`. Pushed data bits above the word length are not sent.
- R3: When `cfg_par_en` is 1, one parity bit follows the data bits. With `cfg_par_even` = 1 it is the XOR of the sent data bits; with 0 it is that XOR inverted. When `cfg_par_en` is 0, no parity bit is sent.
- R4: After the data bits and any parity bit, the line is 1 for one stop bit (`cfg_two_stop` = 0) or two stop bits (`cfg_two_stop` = 1). If more characters are queued, the next start bit follows within one clock of the last stop bit ending. With an empty queue, the line stays 1.
- R5: Word length, parity and stop settings are captured when a frame begins. Changing them during a frame does not alter that frame.
- R6: With `cfg_hs_en` = 1, no frame begins while `cts` is 0, but a frame already under way completes. With `cfg_hs_en` = 0, `cts` has no effect.
- R7: While `cfg_force_brk` is 1, `txd` is 0 in the same cycle. When it returns to 0, `txd` again shows the serializer's line value (1 when idle).
- R8: The queue holds up to 16 characters, and `fifo_count` gives the number queued (0 to 16). `push_ready` is 0 exactly when the count is 16. A push while full is dropped and the count stays 16.
- R9: A one-cycle `cmd_fifo_clr` pulse empties the queue by the next cycle. A push in the same cycle is dropped. Cleared characters are never sent.
- R10: `tx_ready` becomes 1 one clock after `fifo_count` is at or below `cfg_thresh`. While the count is above the threshold and no command is given, `tx_ready` holds its value.
- R11: `cmd_rdy_clr` makes `tx_ready` 0 on the next clock and wins over `cmd_rdy_set` in the same cycle. `cmd_rdy_set` alone makes it 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Oversample tick, one clock wide, 16 per bit |
| push_valid | input | 1 | A character is offered on push_data |
| push_data | input | 8 | Character to queue |
| push_ready | output | 1 | Queue has room |
| cfg_wlen | input | 3 | Data bits per frame minus one |
| cfg_par_en | input | 1 | Send a parity bit |
| cfg_par_even | input | 1 | 1 for even parity, 0 for odd |
| cfg_two_stop | input | 1 | 1 for two stop bits |
| cfg_hs_en | input | 1 | Gate frame starts on cts |
| cfg_force_brk | input | 1 | Hold txd low |
| cfg_thresh | input | 4 | Fill level at or below which tx_ready is raised |
| cts | input | 1 | Clear to send, 1 permits a new frame |
| cmd_fifo_clr | input | 1 | Empty the queue |
| cmd_rdy_clr | input | 1 | Clear tx_ready |
| cmd_rdy_set | input | 1 | Set tx_ready |
| txd | output | 1 | Serial output, idle 1 |
| fifo_count | output | 5 | Characters queued |
| tx_ready | output | 1 | Transmitter-ready flag |

## Verification
Seeded random frame shapes cover all word lengths, both parity senses, parity on and off, and one or two stop bits. Each shape is sent as three back-to-back characters at tick spacings of one, two and three clocks. Varying the spacing separates bit timing counted in ticks from timing counted in clocks, and the gap measured between frames separates one stop bit from two. Directed patterns cover the following:
- a handshake held low before a frame and dropped during a frame, which separates gating of the frame start from gating of the whole frame;
- a configuration change in mid-frame;
- a full queue with an extra push;
- a clear that coincides with a push;
- ready commands given alone and together, and the flag traced against the fill count while the queue drains.

// File: rtl/cfut_pkg.sv
package cfut_pkg;

  typedef enum logic [2:0] {
    FS_IDLE  = 3'd0,
    FS_START = 3'd1,
    FS_DATA  = 3'd2,
    FS_PAR   = 3'd3,
    FS_STOP  = 3'd4
  } fstate_t;

  typedef struct packed {
    logic par_en;
    logic par_even;
    logic two_stop;
  } fopt_t;

endpackage

// File: rtl/cfut_fifo.sv
module cfut_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  input  logic              take,
  output logic [DATA_W-1:0] out_data,
  output logic              out_avail,
  output logic [CNT_W-1:0]  fill
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wp, rp;
  logic [CNT_W-1:0]  cnt;
  logic              do_wr, do_rd;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign in_ready  = (cnt != CNT_W'(DEPTH));
  assign out_avail = (cnt != '0);
  assign out_data  = mem[rp];
  assign fill      = cnt;
  assign do_wr     = in_valid && in_ready && !clr;
  assign do_rd     = take && out_avail && !clr;

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else if (clr) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_wr) wp <= bump(wp);
      if (do_rd) rp <= bump(rp);
      case ({do_wr, do_rd})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R8: the fill never passes the depth
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(DEPTH));

  // R8: an offer while full leaves the fill unchanged
  a_r8_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && in_valid && !take && !clr) |=> $stable(cnt));

  // R9: a clear leaves nothing queued
  a_r9_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!out_avail && cnt == '0));

endmodule

// File: rtl/cfut_framer.sv
module cfut_framer
  import cfut_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16,
  localparam int LEN_W = $clog2(DATA_W),
  localparam int TCK_W = $clog2(OVS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              avail,
  input  logic [DATA_W-1:0] char_in,
  output logic              pop,
  input  logic [LEN_W-1:0]  wlen,
  input  fopt_t             opt,
  input  logic              hs_en,
  input  logic              cts,
  output logic              line,
  output logic              busy
);

  fstate_t           st;
  logic [DATA_W-1:0] sh;
  logic [DATA_W-1:0] masked;
  logic [LEN_W-1:0]  last_idx, idx;
  logic [TCK_W-1:0]  tck;
  fopt_t             opt_q;
  logic              par_q;
  logic              stop_left;
  logic              bit_end;
  logic              go;

  function automatic logic [DATA_W-1:0] len_mask(input logic [LEN_W-1:0] n);
    logic [DATA_W-1:0] m;
    for (int i = 0; i < DATA_W; i++) m[i] = (i <= int'(n));
    return m;
  endfunction

  assign masked  = char_in & len_mask(wlen);
  assign bit_end = tick && (tck == TCK_W'(OVS - 1));
  assign go      = (st == FS_IDLE) && avail && (!hs_en || cts);
  assign pop     = go;
  assign busy    = (st != FS_IDLE);

  always_comb begin
    case (st)
      FS_START: line = 1'b0;
      FS_DATA:  line = sh[0];
      FS_PAR:   line = par_q;
      default:  line = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tck <= '0;
    end else if (go) begin
      tck <= '0;
    end else if (tick && st != FS_IDLE) begin
      tck <= bit_end ? '0 : tck + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= FS_IDLE;
      sh        <= '0;
      last_idx  <= '0;
      idx       <= '0;
      opt_q     <= '0;
      par_q     <= 1'b0;
      stop_left <= 1'b0;
    end else begin
      case (st)
        FS_IDLE: begin
          if (go) begin
            sh       <= masked;
            last_idx <= wlen;
            idx      <= '0;
            opt_q    <= opt;
            par_q    <= (^masked) ^ ~opt.par_even;
            st       <= FS_START;
          end
        end
        FS_START: begin
          if (bit_end) st <= FS_DATA;
        end
        FS_DATA: begin
          if (bit_end) begin
            if (idx == last_idx) begin
              st        <= opt_q.par_en ? FS_PAR : FS_STOP;
              stop_left <= opt_q.two_stop;
            end else begin
              idx <= idx + 1'b1;
              sh  <= sh >> 1;
            end
          end
        end
        FS_PAR: begin
          if (bit_end) st <= FS_STOP;
        end
        FS_STOP: begin
          if (bit_end) begin
            if (stop_left) stop_left <= 1'b0;
            else           st        <= FS_IDLE;
          end
        end
        default: st <= FS_IDLE;
      endcase
    end
  end

  // R2: inside a frame, the state only moves on a tick
  a_r2_step_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (st != $past(st) && $past(st) != FS_IDLE) |-> $past(tick));

  // R6: a frame only begins when the handshake permits it
  a_r6_start_gated: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(!hs_en || cts));

  // R3: a parity bit only appears in frames captured with parity on
  a_r3_par_when_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    (st == FS_PAR) |-> opt_q.par_en);

  // R4: the second stop bit is only pending while stop bits are sent
  a_r4_stop_pending: assert property (@(posedge clk) disable iff (!rst_n)
    stop_left |-> (st == FS_STOP || st == FS_DATA || st == FS_PAR));

endmodule

// File: rtl/cfut_rdyflag.sv
module cfut_rdyflag #(
  parameter int CNT_W = 5,
  parameter int THR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] fill,
  input  logic [THR_W-1:0] thresh,
  input  logic             cmd_clr,
  input  logic             cmd_set,
  output logic             flag
);

  logic low_fill;

  assign low_fill = (fill <= CNT_W'(thresh));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   flag <= 1'b1;
    else if (cmd_clr)             flag <= 1'b0;
    else if (cmd_set || low_fill) flag <= 1'b1;
  end

  // R11: a clear wins over everything
  a_r11_clr_wins: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_clr |=> !flag);

  // R10: a fill at or below the threshold raises the flag
  a_r10_low_fill_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (fill <= CNT_W'(thresh) && !cmd_clr) |=> flag);

  // R10: above the threshold, with no command, the flag holds
  a_r10_hold_above: assert property (@(posedge clk) disable iff (!rst_n)
    (fill > CNT_W'(thresh) && !cmd_clr && !cmd_set) |=> $stable(flag));

endmodule

// File: rtl/cfg_uart_tx.sv
module cfg_uart_tx
  import cfut_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  parameter int OVS    = 16,
  localparam int LEN_W = $clog2(DATA_W),
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int THR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic              push_valid,
  input  logic [DATA_W-1:0] push_data,
  output logic              push_ready,
  input  logic [LEN_W-1:0]  cfg_wlen,
  input  logic              cfg_par_en,
  input  logic              cfg_par_even,
  input  logic              cfg_two_stop,
  input  logic              cfg_hs_en,
  input  logic              cfg_force_brk,
  input  logic [THR_W-1:0]  cfg_thresh,
  input  logic              cts,
  input  logic              cmd_fifo_clr,
  input  logic              cmd_rdy_clr,
  input  logic              cmd_rdy_set,
  output logic              txd,
  output logic [CNT_W-1:0]  fifo_count,
  output logic              tx_ready
);

  logic [DATA_W-1:0] head;
  logic              avail;
  logic              pop;
  logic              line;
  logic              busy;
  fopt_t             opt;

  assign opt = '{par_en: cfg_par_en, par_even: cfg_par_even, two_stop: cfg_two_stop};

  cfut_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (cmd_fifo_clr),
    .in_valid  (push_valid),
    .in_data   (push_data),
    .in_ready  (push_ready),
    .take      (pop),
    .out_data  (head),
    .out_avail (avail),
    .fill      (fifo_count)
  );

  cfut_framer #(.DATA_W(DATA_W), .OVS(OVS)) u_framer (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick16),
    .avail   (avail),
    .char_in (head),
    .pop     (pop),
    .wlen    (cfg_wlen),
    .opt     (opt),
    .hs_en   (cfg_hs_en),
    .cts     (cts),
    .line    (line),
    .busy    (busy)
  );

  cfut_rdyflag #(.CNT_W(CNT_W), .THR_W(THR_W)) u_rdy (
    .clk     (clk),
    .rst_n   (rst_n),
    .fill    (fifo_count),
    .thresh  (cfg_thresh),
    .cmd_clr (cmd_rdy_clr),
    .cmd_set (cmd_rdy_set),
    .flag    (tx_ready)
  );

  assign txd = line & ~cfg_force_brk;

  // R6: an idle serializer stays idle while the handshake blocks it
  a_r6_blocked_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_hs_en && !cts && !busy) |=> !busy);

  // R8: room is only offered below the depth
  a_r8_ready_means_room: assert property (@(posedge clk) disable iff (!rst_n)
    push_ready |-> (fifo_count < CNT_W'(DEPTH)));

  // R4: with nothing sent and nothing queued, the line rests high
  a_r4_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !cfg_force_brk) |-> txd);

endmodule

// File: tb/test_cfg_uart_tx.sv
`timescale 1ns/1ps
module test_cfg_uart_tx;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b0;
  logic       push_valid = 1'b0;
  logic [7:0] push_data = '0;
  logic       push_ready;
  logic [2:0] cfg_wlen = 3'd7;
  logic       cfg_par_en = 1'b0;
  logic       cfg_par_even = 1'b0;
  logic       cfg_two_stop = 1'b0;
  logic       cfg_hs_en = 1'b0;
  logic       cfg_force_brk = 1'b0;
  logic [3:0] cfg_thresh = 4'd3;
  logic       cts = 1'b1;
  logic       cmd_fifo_clr = 1'b0;
  logic       cmd_rdy_clr = 1'b0;
  logic       cmd_rdy_set = 1'b0;
  logic       txd;
  logic [4:0] fifo_count;
  logic       tx_ready;

  int n_tests = 0;
  int n_fail  = 0;
  int tdiv    = 1;
  bit done    = 0;

  cfg_uart_tx i_cfg_uart_tx (
    .clk(clk), .rst_n(rst_n), .tick16(tick16),
    .push_valid(push_valid), .push_data(push_data), .push_ready(push_ready),
    .cfg_wlen(cfg_wlen), .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even),
    .cfg_two_stop(cfg_two_stop), .cfg_hs_en(cfg_hs_en), .cfg_force_brk(cfg_force_brk),
    .cfg_thresh(cfg_thresh), .cts(cts), .cmd_fifo_clr(cmd_fifo_clr),
    .cmd_rdy_clr(cmd_rdy_clr), .cmd_rdy_set(cmd_rdy_set),
    .txd(txd), .fifo_count(fifo_count), .tx_ready(tx_ready)
  );

  always #4 clk = ~clk;

  initial begin : tick_gen
    int c;
    c = 0;
    forever begin
      @(negedge clk);
      if (c >= tdiv - 1) begin c = 0; tick16 = 1'b1; end
      else begin c++; tick16 = 1'b0; end
    end
  end

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      summary();
      $finish;
    end
  end

  task automatic check_eq(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic smp();
    @(negedge clk);
    #1;
  endtask

  task automatic push(input logic [7:0] d);
    @(negedge clk);
    push_valid = 1'b1;
    push_data  = d;
    @(negedge clk);
    push_valid = 1'b0;
  endtask

  function automatic logic [7:0] len_mask(input int nb);
    return 8'((1 << nb) - 1);
  endfunction

  function automatic bit exp_par(input logic [7:0] d, input int nb, input bit even);
    return (^(d & len_mask(nb))) ^ !even;
  endfunction

  // Decode one frame by counting ticks; bit b is sampled at tick 16*b+8.
  task automatic recv(input int nb, input bit pe, input bit two,
                      output logic [7:0] d, output bit st_bit, output bit p,
                      output bit s1, output bit s2);
    logic bits [0:11];
    int total, k, b;
    total = 1 + nb + (pe ? 1 : 0) + (two ? 2 : 1);
    #1;
    while (txd !== 1'b0) smp();
    k = 0;
    b = 0;
    while (1) begin
      if (tick16) begin
        k++;
        if (k == 16 * b + 8) begin
          bits[b] = txd;
          b++;
        end
      end
      if (b == total) break;
      smp();
    end
    st_bit = bits[0];
    d = '0;
    for (int i = 0; i < nb; i++) d[i] = bits[1 + i];
    p  = pe ? bits[1 + nb] : 1'b0;
    s1 = bits[1 + nb + (pe ? 1 : 0)];
    s2 = two ? bits[2 + nb + (pe ? 1 : 0)] : 1'b1;
  endtask

  // Ticks between the last stop sample and the next start; 99 if none within 40.
  task automatic gap_ticks(output int g);
    g = 0;
    while (1) begin
      smp();
      if (txd == 1'b0) break;
      if (tick16) begin
        g++;
        if (g >= 40) begin g = 99; break; end
      end
    end
  endtask

  task automatic check_frame(input logic [7:0] sent, input int nb, input bit pe,
                             input bit even, input bit two, input string tag);
    logic [7:0] d;
    bit st_bit, p, s1, s2;
    recv(nb, pe, two, d, st_bit, p, s1, s2);
    check_eq("R2", {tag, " start bit"}, int'(st_bit), 0);
    check_eq("R2", {tag, " data"}, int'(d), int'(sent & len_mask(nb)));
    if (pe) check_eq("R3", {tag, " parity"}, int'(p), int'(exp_par(sent, nb, even)));
    check_eq("R4", {tag, " stop 1"}, int'(s1), 1);
    if (two) check_eq("R4", {tag, " stop 2"}, int'(s2), 1);
  endtask

  task automatic quiet_window(input int cycles, input int exp_cnt, input string req, input string what);
    int lows;
    lows = 0;
    for (int i = 0; i < cycles; i++) begin
      smp();
      if (txd == 1'b0) lows++;
    end
    check_eq(req, {what, " line low samples"}, lows, 0);
    check_eq(req, {what, " fifo count"}, int'(fifo_count), exp_cnt);
  endtask

  initial begin : main
    int g, errs, prev_cnt;
    logic [7:0] ch [3];
    void'($urandom(32'h1357_2468));

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    smp();
    // R1: reset state
    check_eq("R1", "txd", int'(txd), 1);
    check_eq("R1", "fifo_count", int'(fifo_count), 0);
    check_eq("R1", "push_ready", int'(push_ready), 1);
    check_eq("R1", "tx_ready", int'(tx_ready), 1);

    // R2 R3 R4: seeded random frame shapes, three back-to-back characters each
    for (int it = 0; it < 14; it++) begin
      @(negedge clk);
      tdiv = 1 + int'($urandom_range(2, 0));
      if (it == 0) begin
        cfg_wlen = 3'd7; cfg_par_en = 0; cfg_par_even = 0; cfg_two_stop = 0;
      end else if (it == 1) begin
        cfg_wlen = 3'd4; cfg_par_en = 1; cfg_par_even = 1; cfg_two_stop = 1;
      end else if (it == 2) begin
        cfg_wlen = 3'd0; cfg_par_en = 1; cfg_par_even = 0; cfg_two_stop = 0;
      end else begin
        cfg_wlen     = 3'($urandom_range(7, 0));
        cfg_par_en   = 1'($urandom_range(1, 0));
        cfg_par_even = 1'($urandom_range(1, 0));
        cfg_two_stop = 1'($urandom_range(1, 0));
      end
      for (int j = 0; j < 3; j++) ch[j] = 8'($urandom_range(255, 0));
      fork
        begin
          for (int j = 0; j < 3; j++) push(ch[j]);
        end
        begin
          for (int j = 0; j < 3; j++) begin
            check_frame(ch[j], int'(cfg_wlen) + 1, cfg_par_en, cfg_par_even, cfg_two_stop, "random");
            gap_ticks(g);
            if (j < 2) check_eq("R4", "back-to-back gap within 10 ticks", int'(g <= 10), 1);
            else       check_eq("R4", "idle after last frame", g, 99);
          end
        end
      join
    end

    tdiv = 1;
    @(negedge clk);
    cfg_wlen = 3'd7; cfg_par_en = 0; cfg_par_even = 0; cfg_two_stop = 0;

    // R5: settings changed mid-frame do not affect the frame
    fork
      begin
        push(8'h96);
      end
      begin
        check_frame(8'h96, 8, 0, 0, 0, "R5 mid-frame change");
        gap_ticks(g);
        check_eq("R5", "no extra frame", g, 99);
      end
      begin
        repeat (60) @(negedge clk);
        cfg_wlen = 3'd2; cfg_par_en = 1; cfg_two_stop = 1;
      end
    join
    @(negedge clk);
    cfg_wlen = 3'd7; cfg_par_en = 0; cfg_two_stop = 0;

    // R6: handshake blocks a start
    @(negedge clk);
    cfg_hs_en = 1; cts = 0;
    push(8'hA5);
    quiet_window(200, 1, "R6", "cts low before frame");
    fork
      begin @(negedge clk); cts = 1; end
      check_frame(8'hA5, 8, 0, 0, 0, "R6 released");
    join
    gap_ticks(g);
    check_eq("R6", "single frame after release", g, 99);

    // R6: a drop during a frame lets it complete, then blocks the next
    fork
      begin push(8'h3C); push(8'hC3); end
      check_frame(8'h3C, 8, 0, 0, 0, "R6 drop mid-frame");
      begin repeat (40) @(negedge clk); cts = 0; end
    join
    quiet_window(300, 1, "R6", "cts low after frame");
    fork
      begin @(negedge clk); cts = 1; end
      check_frame(8'hC3, 8, 0, 0, 0, "R6 second released");
    join
    gap_ticks(g);

    // R6: handshake disabled, cts ignored
    @(negedge clk);
    cfg_hs_en = 0; cts = 0;
    fork
      push(8'h5A);
      check_frame(8'h5A, 8, 0, 0, 0, "R6 handshake off");
    join
    gap_ticks(g);
    check_eq("R6", "handshake off single frame", g, 99);

    // R7: break override
    @(negedge clk);
    cfg_force_brk = 1;
    #1;
    check_eq("R7", "txd under break", int'(txd), 0);
    repeat (5) smp();
    check_eq("R7", "txd held under break", int'(txd), 0);
    check_eq("R7", "count unchanged by break", int'(fifo_count), 0);
    @(negedge clk);
    cfg_force_brk = 0;
    #1;
    check_eq("R7", "txd after break", int'(txd), 1);

    // R8: fill to the depth with the serializer held
    @(negedge clk);
    cfg_hs_en = 1; cts = 0; cfg_thresh = 4'd3;
    for (int i = 0; i < 16; i++) push(8'(i + 1));
    #1;
    check_eq("R8", "count at depth", int'(fifo_count), 16);
    check_eq("R8", "push_ready when full", int'(push_ready), 0);
    push(8'hEE);
    #1;
    check_eq("R8", "count after push while full", int'(fifo_count), 16);
    check_eq("R10", "flag held above threshold", int'(tx_ready), 1);

    // R11: commands
    @(negedge clk); cmd_rdy_clr = 1;
    @(negedge clk); cmd_rdy_clr = 0;
    #1;
    check_eq("R11", "flag after clear", int'(tx_ready), 0);
    repeat (5) smp();
    check_eq("R10", "cleared flag holds above threshold", int'(tx_ready), 0);
    @(negedge clk); cmd_rdy_set = 1;
    @(negedge clk); cmd_rdy_set = 0;
    #1;
    check_eq("R11", "flag after set", int'(tx_ready), 1);
    @(negedge clk); cmd_rdy_set = 1; cmd_rdy_clr = 1;
    @(negedge clk); cmd_rdy_set = 0; cmd_rdy_clr = 0;
    #1;
    check_eq("R11", "clear wins over set", int'(tx_ready), 0);

    // R9: clear with a simultaneous push
    @(negedge clk); cmd_fifo_clr = 1; push_valid = 1; push_data = 8'h77;
    @(negedge clk); cmd_fifo_clr = 0; push_valid = 0;
    #1;
    check_eq("R9", "count after clear", int'(fifo_count), 0);
    check_eq("R9", "push_ready after clear", int'(push_ready), 1);
    check_eq("R10", "flag one clock before low fill seen", int'(tx_ready), 0);
    smp();
    check_eq("R10", "flag one clock after low fill", int'(tx_ready), 1);
    @(negedge clk); cts = 1;
    quiet_window(400, 0, "R9", "cleared characters");

    // R10: trace the flag while the queue drains
    @(negedge clk); cts = 0;
    for (int i = 0; i < 6; i++) push(8'(8'h40 + i));
    @(negedge clk); cmd_rdy_clr = 1;
    @(negedge clk); cmd_rdy_clr = 0;
    #1;
    check_eq("R10", "drain start flag", int'(tx_ready), 0);
    prev_cnt = int'(fifo_count);
    errs = 0;
    @(negedge clk); cts = 1;
    #1;
    for (int i = 0; i < 1600; i++) begin
      if (prev_cnt <= 3 && !tx_ready) errs++;
      if (prev_cnt > 3 && tx_ready) errs++;
      prev_cnt = int'(fifo_count);
      smp();
    end
    check_eq("R10", "flag tracks fill during drain (mismatches)", errs, 0);
    check_eq("R10", "drained count", int'(fifo_count), 0);
    repeat (300) smp();
    check_eq("R4", "line idle after drain", int'(txd), 1);

    done = 1;
    summary();
    $finish;
  end

endmodule